// File: doc/BRIEF.md
# Cache-Line AXI4 Master Bridge

This block sits between a data cache and an AXI4 memory fabric. The cache asks it to fetch one full line (a refill) or to store one full line (a writeback). The bridge turns each request into an AXI4 transaction and, when the bus response arrives, returns a one-cycle completion pulse with a success flag. A single line address bus serves both directions. A line is 256 bits by default and always moves as one burst beat.

Read and write are handled by separate engines. Inside the write engine, the AW, W and B channels each keep their own state. A write address can therefore be accepted while the write data is still waiting, and a read can run from start to finish while a write is stalled on the bus. A VALID output never waits for its READY input. A bus response code other than OKAY still finishes the transaction, but the success flag stays low.

Top module: `line_axi_bridge`

## Requirements
- R1: After synchronous reset, AWVALID, WVALID, ARVALID, BREADY, RREADY and both done pulses are low, and both cache-side ready outputs are high.
- R2: An accepted write request (wr_vld_i and wr_rdy_o high at a clock edge) raises AWVALID and WVALID on the next cycle. AWADDR equals the request address and WDATA equals the request line. AWLEN is 0, AWSIZE is 5 (32 bytes for a 256-bit line), AWBURST is INCR (2'b01), WSTRB is all ones, and WLAST is high on that single beat.
- R3: Once AWVALID, WVALID or ARVALID is high, it stays high with an unchanged address or data while its READY is low. It goes low on the cycle after its handshake.
- R4: The AW and W handshakes may finish in either order. BREADY is high only after both have finished and the B response has not yet been taken.
- R5: On the cycle after the B handshake, wr_done_o pulses for one cycle and wr_rdy_o is high again. wr_ok_o is high in that cycle only if BRESP was OKAY (2'b00). Any other code gives done without ok.
- R6: An accepted read request raises ARVALID on the next cycle. ARADDR equals the request address, ARLEN is 0, ARSIZE is 5 and ARBURST is INCR. RREADY stays low until the AR handshake has finished.
- R7: On the cycle after an R handshake with RLAST high, rd_done_o pulses for one cycle and rd_line_o holds that beat's RDATA. rd_ok_o is high only if every beat of the burst returned RRESP OKAY (2'b00).
- R8: A read can be accepted and can complete while a write is still waiting on its W handshake. The pending WVALID and WDATA are not disturbed.
- R9: While a direction is busy, its cache-side ready output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_addr_i | input | ADDR_W | Line address for the request being offered |
| rd_vld_i | input | 1 | Cache offers a line fetch |
| rd_rdy_o | output | 1 | Read engine can accept a fetch |
| rd_line_o | output | LINE_W | Fetched line data |
| rd_ok_o | output | 1 | Fetch ended with OKAY responses |
| rd_done_o | output | 1 | One-cycle pulse at fetch end |
| wr_vld_i | input | 1 | Cache offers a line store |
| wr_rdy_o | output | 1 | Write engine can accept a store |
| wr_line_i | input | LINE_W | Line data to store |
| wr_ok_o | output | 1 | Store ended with OKAY response |
| wr_done_o | output | 1 | One-cycle pulse at store end |
| m_awaddr | output | ADDR_W | Write address |
| m_awlen | output | 8 | Burst length minus one (always 0) |
| m_awsize | output | 3 | Beat size code |
| m_awburst | output | 2 | Burst type (INCR) |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | LINE_W | Write data |
| m_wstrb | output | LINE_W/8 | Byte strobes (all ones) |
| m_wlast | output | 1 | Last write beat |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | ADDR_W | Read address |
| m_arlen | output | 8 | Burst length minus one (always 0) |
| m_arsize | output | 3 | Beat size code |
| m_arburst | output | 2 | Burst type (INCR) |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | LINE_W | Read data |
| m_rresp | input | 2 | Read response code |
| m_rlast | input | 1 | Last read beat |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
The bench builds the bridge with its default values: a 32-bit address and a 256-bit line. At this line width every interesting data and strobe bit is visible, and the size code of 5 can be checked directly. Because each AXI ready and response is scripted by hand, the bench can hold a channel stalled for several cycles and can finish the AW and W handshakes in either order. It can also complete a read while a write is still waiting on its W channel. Each error code is returned only after the handshake order has been fixed, so the success flag is seen on its own.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

    localparam int LBR_ADDR_W = 32;
    localparam int LBR_LINE_W = 256;

    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_EXOKAY = 2'b01,
        RESP_SLVERR = 2'b10,
        RESP_DECERR = 2'b11
    } axi_resp_e;

    typedef enum logic [1:0] {
        BURST_FIXED = 2'b00,
        BURST_INCR  = 2'b01,
        BURST_WRAP  = 2'b10
    } axi_burst_e;

    function automatic logic resp_good(input logic [1:0] code);
        return axi_resp_e'(code) == RESP_OKAY;
    endfunction

    function automatic logic [2:0] size_code(input int bytes);
        return 3'($clog2(bytes));
    endfunction

endpackage

// File: rtl/lbr_chan_slot.sv
module lbr_chan_slot #(
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [PW-1:0] load_d,
    input  logic          ready,
    output logic          valid,
    output logic [PW-1:0] payload
);
    logic          vld_q;
    logic [PW-1:0] pay_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            pay_q <= '0;
        end else begin
            if (load) begin
                vld_q <= 1'b1;
                pay_q <= load_d;
            end else if (vld_q && ready) begin
                vld_q <= 1'b0;
            end
        end
    end

    assign valid   = vld_q;
    assign payload = pay_q;
endmodule

// File: rtl/lbr_wr_engine.sv
module lbr_wr_engine
    import lbr_pkg::*;
#(
    parameter int ADDR_W = LBR_ADDR_W,
    parameter int LINE_W = LBR_LINE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_vld,
    output logic              req_rdy,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LINE_W-1:0] req_line,
    output logic              done,
    output logic              ok,
    output logic              awvalid,
    input  logic              awready,
    output logic [ADDR_W-1:0] awaddr,
    output logic              wvalid,
    input  logic              wready,
    output logic [LINE_W-1:0] wdata,
    input  logic              bvalid,
    output logic              bready,
    input  logic [1:0]        bresp
);
    logic busy_q, done_q, ok_q;
    logic accept, b_hs;

    assign accept  = req_vld && !busy_q;
    assign req_rdy = !busy_q;

    lbr_chan_slot #(.PW(ADDR_W)) aw_slot (
        .clk(clk), .rst(rst), .load(accept), .load_d(req_addr),
        .ready(awready), .valid(awvalid), .payload(awaddr)
    );

    lbr_chan_slot #(.PW(LINE_W)) w_slot (
        .clk(clk), .rst(rst), .load(accept), .load_d(req_line),
        .ready(wready), .valid(wvalid), .payload(wdata)
    );

    // response channel opens only once address and data are both gone
    assign bready = busy_q && !awvalid && !wvalid;
    assign b_hs   = bvalid && bready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            ok_q   <= 1'b0;
        end else begin
            done_q <= b_hs;
            ok_q   <= b_hs && resp_good(bresp);
            if (accept)    busy_q <= 1'b1;
            else if (b_hs) busy_q <= 1'b0;
        end
    end

    assign done = done_q;
    assign ok   = ok_q;
endmodule

// File: rtl/lbr_rd_engine.sv
module lbr_rd_engine
    import lbr_pkg::*;
#(
    parameter int ADDR_W = LBR_ADDR_W,
    parameter int LINE_W = LBR_LINE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_vld,
    output logic              req_rdy,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [LINE_W-1:0] line,
    output logic              done,
    output logic              ok,
    output logic              arvalid,
    input  logic              arready,
    output logic [ADDR_W-1:0] araddr,
    input  logic              rvalid,
    output logic              rready,
    input  logic [LINE_W-1:0] rdata,
    input  logic [1:0]        rresp,
    input  logic              rlast
);
    logic              busy_q, done_q, ok_q, err_q;
    logic [LINE_W-1:0] line_q;
    logic              accept, r_hs, r_end;

    assign accept  = req_vld && !busy_q;
    assign req_rdy = !busy_q;

    lbr_chan_slot #(.PW(ADDR_W)) ar_slot (
        .clk(clk), .rst(rst), .load(accept), .load_d(req_addr),
        .ready(arready), .valid(arvalid), .payload(araddr)
    );

    assign rready = busy_q && !arvalid;
    assign r_hs   = rvalid && rready;
    assign r_end  = r_hs && rlast;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            ok_q   <= 1'b0;
            err_q  <= 1'b0;
            line_q <= '0;
        end else begin
            done_q <= r_end;
            ok_q   <= r_end && !err_q && resp_good(rresp);
            if (r_hs) line_q <= rdata;
            if (accept)                 err_q <= 1'b0;
            else if (r_hs && !resp_good(rresp)) err_q <= 1'b1;
            if (accept)     busy_q <= 1'b1;
            else if (r_end) busy_q <= 1'b0;
        end
    end

    assign line = line_q;
    assign done = done_q;
    assign ok   = ok_q;
endmodule

// File: rtl/line_axi_bridge.sv
module line_axi_bridge
    import lbr_pkg::*;
#(
    parameter int ADDR_W = LBR_ADDR_W,
    parameter int LINE_W = LBR_LINE_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     line_addr_i,
    input  logic                  rd_vld_i,
    output logic                  rd_rdy_o,
    output logic [LINE_W-1:0]     rd_line_o,
    output logic                  rd_ok_o,
    output logic                  rd_done_o,
    input  logic                  wr_vld_i,
    output logic                  wr_rdy_o,
    input  logic [LINE_W-1:0]     wr_line_i,
    output logic                  wr_ok_o,
    output logic                  wr_done_o,
    output logic [ADDR_W-1:0]     m_awaddr,
    output logic [7:0]            m_awlen,
    output logic [2:0]            m_awsize,
    output logic [1:0]            m_awburst,
    output logic                  m_awvalid,
    input  logic                  m_awready,
    output logic [LINE_W-1:0]     m_wdata,
    output logic [LINE_W/8-1:0]   m_wstrb,
    output logic                  m_wlast,
    output logic                  m_wvalid,
    input  logic                  m_wready,
    input  logic [1:0]            m_bresp,
    input  logic                  m_bvalid,
    output logic                  m_bready,
    output logic [ADDR_W-1:0]     m_araddr,
    output logic [7:0]            m_arlen,
    output logic [2:0]            m_arsize,
    output logic [1:0]            m_arburst,
    output logic                  m_arvalid,
    input  logic                  m_arready,
    input  logic [LINE_W-1:0]     m_rdata,
    input  logic [1:0]            m_rresp,
    input  logic                  m_rlast,
    input  logic                  m_rvalid,
    output logic                  m_rready
);
    localparam int         LINE_BYTES = LINE_W / 8;
    localparam logic [2:0] BEAT_SIZE  = size_code(LINE_BYTES);

    lbr_wr_engine #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) wr_eng (
        .clk(clk), .rst(rst),
        .req_vld(wr_vld_i), .req_rdy(wr_rdy_o),
        .req_addr(line_addr_i), .req_line(wr_line_i),
        .done(wr_done_o), .ok(wr_ok_o),
        .awvalid(m_awvalid), .awready(m_awready), .awaddr(m_awaddr),
        .wvalid(m_wvalid), .wready(m_wready), .wdata(m_wdata),
        .bvalid(m_bvalid), .bready(m_bready), .bresp(m_bresp)
    );

    lbr_rd_engine #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) rd_eng (
        .clk(clk), .rst(rst),
        .req_vld(rd_vld_i), .req_rdy(rd_rdy_o),
        .req_addr(line_addr_i), .line(rd_line_o),
        .done(rd_done_o), .ok(rd_ok_o),
        .arvalid(m_arvalid), .arready(m_arready), .araddr(m_araddr),
        .rvalid(m_rvalid), .rready(m_rready), .rdata(m_rdata),
        .rresp(m_rresp), .rlast(m_rlast)
    );

    // one line per burst: a single beat of full width
    assign m_awlen   = 8'd0;
    assign m_arlen   = 8'd0;
    assign m_awsize  = BEAT_SIZE;
    assign m_arsize  = BEAT_SIZE;
    assign m_awburst = BURST_INCR;
    assign m_arburst = BURST_INCR;
    assign m_wstrb   = '1;
    assign m_wlast   = m_wvalid;
endmodule

// File: rtl/lbr_checker.sv
module lbr_checker #(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 256
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_rdy_o,
    input logic              rd_ok_o,
    input logic              rd_done_o,
    input logic              wr_rdy_o,
    input logic              wr_ok_o,
    input logic              wr_done_o,
    input logic [ADDR_W-1:0] m_awaddr,
    input logic              m_awvalid,
    input logic              m_awready,
    input logic [LINE_W-1:0] m_wdata,
    input logic              m_wlast,
    input logic              m_wvalid,
    input logic              m_wready,
    input logic              m_bvalid,
    input logic              m_bready,
    input logic [ADDR_W-1:0] m_araddr,
    input logic              m_arvalid,
    input logic              m_arready,
    input logic              m_rlast,
    input logic              m_rvalid,
    input logic              m_rready
);
    AST_AW_HOLD: assert property (@(posedge clk) disable iff (rst)
        m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr)); // R3
    AST_W_HOLD: assert property (@(posedge clk) disable iff (rst)
        m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata)); // R3
    AST_AR_HOLD: assert property (@(posedge clk) disable iff (rst)
        m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr)); // R3
    AST_AW_DROP: assert property (@(posedge clk) disable iff (rst)
        m_awvalid && m_awready |=> !m_awvalid); // R3
    AST_WLAST_BEAT: assert property (@(posedge clk) disable iff (rst)
        m_wvalid |-> m_wlast); // R2
    AST_B_AFTER_BOTH: assert property (@(posedge clk) disable iff (rst)
        m_bready |-> !m_awvalid && !m_wvalid); // R4
    AST_WR_DONE_SRC: assert property (@(posedge clk) disable iff (rst)
        wr_done_o |-> $past(m_bvalid && m_bready)); // R5
    AST_WR_OK_IN_DONE: assert property (@(posedge clk) disable iff (rst)
        wr_ok_o |-> wr_done_o); // R5
    AST_WR_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_done_o |=> !wr_done_o); // R5
    AST_R_AFTER_AR: assert property (@(posedge clk) disable iff (rst)
        m_rready |-> !m_arvalid); // R6
    AST_RD_DONE_SRC: assert property (@(posedge clk) disable iff (rst)
        rd_done_o |-> $past(m_rvalid && m_rready && m_rlast)); // R7
    AST_RD_OK_IN_DONE: assert property (@(posedge clk) disable iff (rst)
        rd_ok_o |-> rd_done_o); // R7
    AST_WR_BUSY: assert property (@(posedge clk) disable iff (rst)
        m_awvalid || m_wvalid || m_bready |-> !wr_rdy_o); // R9
    AST_RD_BUSY: assert property (@(posedge clk) disable iff (rst)
        m_arvalid || m_rready |-> !rd_rdy_o); // R9
endmodule

bind line_axi_bridge lbr_checker #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) chk_i (.*);

// File: tb/line_axi_bridge_tb_top.sv
module line_axi_bridge_tb_top;
    localparam int AW = 32;
    localparam int LW = 256;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [AW-1:0] line_addr_i = '0;
    logic rd_vld_i = 0, wr_vld_i = 0;
    logic [LW-1:0] wr_line_i = '0;
    logic rd_rdy_o, rd_ok_o, rd_done_o, wr_rdy_o, wr_ok_o, wr_done_o;
    logic [LW-1:0] rd_line_o;
    logic [AW-1:0] m_awaddr, m_araddr;
    logic [7:0] m_awlen, m_arlen;
    logic [2:0] m_awsize, m_arsize;
    logic [1:0] m_awburst, m_arburst;
    logic m_awvalid, m_wlast, m_wvalid, m_bready, m_arvalid, m_rready;
    logic [LW-1:0] m_wdata;
    logic [LW/8-1:0] m_wstrb;
    logic m_awready = 0, m_wready = 0, m_bvalid = 0, m_arready = 0;
    logic m_rlast = 0, m_rvalid = 0;
    logic [1:0] m_bresp = 0, m_rresp = 0;
    logic [LW-1:0] m_rdata = '0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    line_axi_bridge dut_i (.*);

    task automatic check(input bit cond, input string req, input string what,
                         input logic [LW-1:0] act, input logic [LW-1:0] exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic ceq(input string req, input string what,
                       input logic [LW-1:0] act, input logic [LW-1:0] exp);
        check(act === exp, req, what, act, exp);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic issue_write(input logic [AW-1:0] a, input logic [LW-1:0] d);
        line_addr_i = a; wr_line_i = d; wr_vld_i = 1;
        tick();
        wr_vld_i = 0;
    endtask

    task automatic issue_read(input logic [AW-1:0] a);
        line_addr_i = a; rd_vld_i = 1;
        tick();
        rd_vld_i = 0;
    endtask

    task automatic test_reset();
        ceq("R1", "awvalid", m_awvalid, 0);
        ceq("R1", "wvalid", m_wvalid, 0);
        ceq("R1", "arvalid", m_arvalid, 0);
        ceq("R1", "bready", m_bready, 0);
        ceq("R1", "rready", m_rready, 0);
        ceq("R1", "wr_rdy", wr_rdy_o, 1);
        ceq("R1", "rd_rdy", rd_rdy_o, 1);
        ceq("R1", "dones", {wr_done_o, rd_done_o}, 0);
    endtask

    task automatic test_write_aw_first();
        logic [LW-1:0] d = {8{32'hA5C3_0F1E}} ^ {{(LW-32){1'b0}}, 32'h1234};
        issue_write(32'h0000_1240, d);
        ceq("R2", "awvalid", m_awvalid, 1);
        ceq("R2", "awaddr", m_awaddr, 32'h0000_1240);
        ceq("R2", "awlen/size/burst", {m_awlen, m_awsize, m_awburst}, {8'd0, 3'd5, 2'b01});
        ceq("R2", "wvalid", m_wvalid, 1);
        ceq("R2", "wdata", m_wdata, d);
        ceq("R2", "wstrb", m_wstrb, {(LW/8){1'b1}});
        ceq("R2", "wlast", m_wlast, 1);
        ceq("R9", "wr_rdy busy", wr_rdy_o, 0);
        tick(); tick();
        ceq("R3", "awvalid held", m_awvalid, 1);
        ceq("R3", "awaddr held", m_awaddr, 32'h0000_1240);
        ceq("R3", "wdata held", m_wdata, d);
        ceq("R4", "bready early", m_bready, 0);
        m_awready = 1; tick(); m_awready = 0;
        ceq("R3", "awvalid dropped", m_awvalid, 0);
        ceq("R4", "bready w pending", m_bready, 0);
        m_wready = 1; tick(); m_wready = 0;
        ceq("R3", "wvalid dropped", m_wvalid, 0);
        ceq("R4", "bready after both", m_bready, 1);
        ceq("R5", "no done yet", wr_done_o, 0);
        m_bvalid = 1; m_bresp = 2'b00; tick(); m_bvalid = 0;
        ceq("R5", "wr_done", wr_done_o, 1);
        ceq("R5", "wr_ok okay", wr_ok_o, 1);
        ceq("R5", "wr_rdy back", wr_rdy_o, 1);
        ceq("R4", "bready off", m_bready, 0);
        tick();
        ceq("R5", "done one cycle", wr_done_o, 0);
    endtask

    task automatic test_write_w_first_err();
        logic [LW-1:0] d = {LW/16{16'h5AA5}};
        issue_write(32'h8000_0020, d);
        m_wready = 1; tick(); m_wready = 0;
        ceq("R4", "wvalid gone first", m_wvalid, 0);
        ceq("R4", "awvalid still", m_awvalid, 1);
        ceq("R4", "bready aw pending", m_bready, 0);
        m_awready = 1; tick(); m_awready = 0;
        ceq("R4", "bready after both", m_bready, 1);
        m_bvalid = 1; m_bresp = 2'b10; tick(); m_bvalid = 0; m_bresp = 0;
        ceq("R5", "wr_done slverr", wr_done_o, 1);
        ceq("R5", "wr_ok slverr", wr_ok_o, 0);
        tick();
        issue_write(32'h8000_0040, d);
        m_awready = 1; m_wready = 1; tick(); m_awready = 0; m_wready = 0;
        m_bvalid = 1; m_bresp = 2'b01; tick(); m_bvalid = 0; m_bresp = 0;
        ceq("R5", "wr_done exokay", wr_done_o, 1);
        ceq("R5", "wr_ok exokay", wr_ok_o, 0);
        tick();
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [LW-1:0] d,
                           input logic [1:0] resp, input bit exp_ok);
        issue_read(a);
        ceq("R6", "arvalid", m_arvalid, 1);
        ceq("R6", "araddr", m_araddr, a);
        ceq("R6", "arlen/size/burst", {m_arlen, m_arsize, m_arburst}, {8'd0, 3'd5, 2'b01});
        ceq("R6", "rready before ar", m_rready, 0);
        ceq("R9", "rd_rdy busy", rd_rdy_o, 0);
        tick();
        ceq("R3", "arvalid held", m_arvalid, 1);
        m_arready = 1; tick(); m_arready = 0;
        ceq("R3", "arvalid dropped", m_arvalid, 0);
        ceq("R6", "rready after ar", m_rready, 1);
        m_rvalid = 1; m_rlast = 1; m_rdata = d; m_rresp = resp;
        tick();
        m_rvalid = 0; m_rlast = 0; m_rdata = '0; m_rresp = 0;
        ceq("R7", "rd_done", rd_done_o, 1);
        ceq("R7", "rd_line", rd_line_o, d);
        ceq("R7", "rd_ok", rd_ok_o, exp_ok);
        ceq("R7", "rd_rdy back", rd_rdy_o, 1);
        tick();
        ceq("R7", "rd_done one cycle", rd_done_o, 0);
    endtask

    task automatic test_overlap();
        logic [LW-1:0] wd = {LW/32{32'hDEAD_BEEF}};
        logic [LW-1:0] rd = {LW/32{32'h0BAD_F00D}};
        issue_write(32'h0000_4000, wd);
        m_awready = 1; tick(); m_awready = 0;
        do_read(32'h0000_6000, rd, 2'b00, 1);
        ceq("R8", "wvalid still pending", m_wvalid, 1);
        ceq("R8", "wdata undisturbed", m_wdata, wd);
        ceq("R8", "no write done", wr_done_o, 0);
        m_wready = 1; tick(); m_wready = 0;
        m_bvalid = 1; tick(); m_bvalid = 0;
        ceq("R8", "write completes", {wr_done_o, wr_ok_o}, 2'b11);
        tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        tick();
        test_reset();
        test_write_aw_first();
        test_write_w_first_err();
        do_read(32'h0000_2000, {LW/32{32'h1357_9BDF}}, 2'b00, 1);
        do_read(32'h0000_2020, {LW/32{32'h2468_ACE0}}, 2'b11, 0);
        test_overlap();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule